// File: doc/BRIEF.md
# Serial Front-End Command Decoder

This block sits at the serial control port of a front-end readout chip. It watches one data line that a command clock samples. A frame starts when a 1 appears on an idle line. The frame then carries a chip address and a command code. The block compares the address with the strap pins of its own chip. After that it takes whatever payload the command calls for and acts on it.

Load commands write one of five configuration registers: the data, calibration and trigger channel masks, a pair of 7-bit DAC settings and a 2-bit mode register. The read commands send a register back on a serial return line. One command starts an event readout, and another clears every register. The deaf bit of the mode register blocks the trigger that comes in from the previous chip in the chain.

Frames with another chip's address pass through the receiver bit by bit, so the frame boundaries stay correct. Such a frame has no effect.

Top module: `sfe_cmd_decoder`

## Requirements
- R1: A frame begins with a 1 sampled in ST_IDLE, where 0 bits are ignored. ST_HEAD then takes ten bits: a 5-bit address followed by a 5-bit command code, each sent MSB first.
- R2: When the frame address differs from `chip_addr`, the whole frame is still clocked in. It updates no register, raises no strobe and starts no readback.
- R3: The three mask loads use codes 01000 (data), 01001 (calibration) and 01010 (trigger). Each takes 68 payload bits in four groups of 17. Every group is a marker bit followed by 16 channel bits sent from the highest channel down, so mask bit 63 arrives at serial position 1 and mask bit 0 at position 67.
- R4: If any marker bit at serial positions 0, 17, 34 or 51 is 0, the mask load is discarded. `mask_err` is then high for exactly one cycle.
- R5: Load DAC (01011) takes 68 bits, and only the last 14 are used. Serial positions 54..59 are `cal_dac[0..5]`, position 60 is `cal_range`, positions 61..66 are `thr_dac[0..5]` and position 67 is `thr_range`.
- R6: Load mode (01100) with `legacy_mode` low takes `read_dir` (1 means right) from serial position 66 and `deaf` from position 67.
- R7: With `legacy_mode` high, load mode takes `read_dir` from serial position 65 and `deaf` from position 66.
- R8: `trig_out` equals `trig_in` while `deaf` is 0, and it is 0 while `deaf` is 1.
- R9: Read-event (00100) takes two more bits, B1 then B0. `evt_start` then pulses for one cycle, and `evt_sel` = {B1,B0} holds until the next read-event.
- R10: Chip reset (00010) has no payload. It clears every configuration register and pulses `chip_rst` for one cycle.
- R11: The read codes are 10000 (data mask), 10001 (calibration mask), 10010 (trigger mask), 10011 (DAC) and 10100 (mode). Each one starts ST_SEND in the cycle after the last header bit. ST_SEND drives 68 bits on `sdo` with `sdo_vld` high, in the same layout the matching load uses. Markers are 1, unused bits are 0, and the mode layout follows `legacy_mode`. `sdo` is 0 whenever `sdo_vld` is low.
- R12: The no-op (00000) and any unassigned code end the frame after the header, with no payload and no effect. A start bit in the next cycle is accepted.
- R13: Register updates and strobes become visible in the cycle after the clock edge that samples the frame's last bit. Only one strobe is ever active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial command line |
| chip_addr | input | 5 | Strapped chip address |
| legacy_mode | input | 1 | Selects the shifted mode-register layout |
| trig_in | input | 1 | Trigger from the previous chip |
| trig_out | output | 1 | Trigger after deaf gating |
| data_mask | output | 64 | Data channel mask |
| cal_mask | output | 64 | Calibration channel mask |
| trig_mask | output | 64 | Trigger channel mask |
| cal_dac | output | 6 | Calibration DAC value |
| cal_range | output | 1 | Calibration DAC range |
| thr_dac | output | 6 | Threshold DAC value |
| thr_range | output | 1 | Threshold DAC range |
| read_dir | output | 1 | Readout direction (0 left, 1 right) |
| deaf | output | 1 | Blocks the incoming trigger |
| chip_rst | output | 1 | One-cycle chip reset strobe |
| evt_start | output | 1 | One-cycle event readout start |
| evt_sel | output | 2 | Selected event register |
| mask_err | output | 1 | One-cycle bad-marker flag |
| sdo | output | 1 | Serial return data |
| sdo_vld | output | 1 | Return data valid |

## Verification
Each mask pattern is checked by reading it back and by a load with a single bad marker in the third group. A bit-order or group-offset mistake shows up as a shifted or reversed mask. A missing marker check lets the corrupt pattern overwrite the old mask. DAC loads put nonzero bits in the ignored part of the payload, so a decoder that reads the wrong window picks up garbage values. The mode register is loaded in both layouts, and a mix-up there swaps or loses the direction and deaf bits, which also shows on the gated trigger. Frames to another address, an unassigned code followed at once by a valid frame, and a reset to another address all confirm the frame length: a receiver that miscounts will misread every command that follows.

// File: rtl/sfe_cmd_pkg.sv
package sfe_cmd_pkg;

    localparam int ADDR_W    = 5;
    localparam int CODE_W    = 5;
    localparam int HDR_W     = ADDR_W + CODE_W;
    localparam int PAY_W     = 68;
    localparam int GRP_N     = 4;
    localparam int GRP_W     = PAY_W / GRP_N;
    localparam int CH_N      = GRP_N * (GRP_W - 1);
    localparam int DAC_W     = 6;
    localparam int DAC_FLD_W = 2 * (DAC_W + 1);
    localparam int EVT_W     = 2;
    localparam int CNT_W     = $clog2(PAY_W + 1);

    typedef enum logic [CODE_W-1:0] {
        CMD_NOP      = 5'b00000,
        CMD_RESET    = 5'b00010,
        CMD_EVT      = 5'b00100,
        CMD_LD_DMASK = 5'b01000,
        CMD_LD_CMASK = 5'b01001,
        CMD_LD_TMASK = 5'b01010,
        CMD_LD_DAC   = 5'b01011,
        CMD_LD_MODE  = 5'b01100,
        CMD_RD_DMASK = 5'b10000,
        CMD_RD_CMASK = 5'b10001,
        CMD_RD_TMASK = 5'b10010,
        CMD_RD_DAC   = 5'b10011,
        CMD_RD_MODE  = 5'b10100
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_EVSEL,
        ST_LOAD,
        ST_SEND
    } state_e;

    typedef enum logic [2:0] {
        RB_DMASK,
        RB_CMASK,
        RB_TMASK,
        RB_DAC,
        RB_MODE
    } rb_sel_e;

    function automatic logic is_mask_load(input logic [CODE_W-1:0] c);
        return (c == CMD_LD_DMASK) || (c == CMD_LD_CMASK) || (c == CMD_LD_TMASK);
    endfunction

    function automatic logic is_load(input logic [CODE_W-1:0] c);
        return is_mask_load(c) || (c == CMD_LD_DAC) || (c == CMD_LD_MODE);
    endfunction

    function automatic logic is_read(input logic [CODE_W-1:0] c);
        return (c == CMD_RD_DMASK) || (c == CMD_RD_CMASK) || (c == CMD_RD_TMASK)
            || (c == CMD_RD_DAC) || (c == CMD_RD_MODE);
    endfunction

endpackage

// File: rtl/sfe_mask_unpack.sv
module sfe_mask_unpack
    import sfe_cmd_pkg::*;
#(
    parameter int N_GRP = GRP_N,
    parameter int W_GRP = GRP_W,
    localparam int P_W  = N_GRP * W_GRP,
    localparam int C_N  = N_GRP * (W_GRP - 1)
) (
    input  logic [P_W-1:0] payload,
    output logic [C_N-1:0] mask,
    output logic           markers_ok
);
    logic [N_GRP-1:0] mark;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign mark[g] = payload[P_W-1-g*W_GRP];
        assign mask[C_N-1-g*(W_GRP-1) -: (W_GRP-1)] = payload[P_W-2-g*W_GRP -: (W_GRP-1)];
    end

    assign markers_ok = &mark;
endmodule

// File: rtl/sfe_mask_pack.sv
module sfe_mask_pack
    import sfe_cmd_pkg::*;
#(
    parameter int N_GRP = GRP_N,
    parameter int W_GRP = GRP_W,
    localparam int P_W  = N_GRP * W_GRP,
    localparam int C_N  = N_GRP * (W_GRP - 1)
) (
    input  logic [C_N-1:0] mask,
    output logic [P_W-1:0] image
);
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign image[P_W-1-g*W_GRP] = 1'b1;
        assign image[P_W-2-g*W_GRP -: (W_GRP-1)] = mask[C_N-1-g*(W_GRP-1) -: (W_GRP-1)];
    end
endmodule

// File: rtl/sfe_cfg_regs.sv
module sfe_cfg_regs
    import sfe_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 ld_dmask,
    input  logic                 ld_cmask,
    input  logic                 ld_tmask,
    input  logic                 ld_dac,
    input  logic                 ld_mode,
    input  logic                 legacy,
    input  logic [CH_N-1:0]      mask_in,
    input  logic [DAC_FLD_W-1:0] tail,
    output logic [CH_N-1:0]      data_mask,
    output logic [CH_N-1:0]      cal_mask,
    output logic [CH_N-1:0]      trig_mask,
    output logic [DAC_W-1:0]     cal_dac,
    output logic                 cal_range,
    output logic [DAC_W-1:0]     thr_dac,
    output logic                 thr_range,
    output logic                 read_dir,
    output logic                 deaf
);
    localparam int CAL_TOP  = DAC_FLD_W - 1;
    localparam int CAL_RNG  = CAL_TOP - DAC_W;
    localparam int THR_TOP  = CAL_RNG - 1;
    localparam int THR_RNG  = 0;
    localparam int DEAF_POS = 0;
    localparam int DIR_POS  = 1;

    logic [DAC_W-1:0] cal_new;
    logic [DAC_W-1:0] thr_new;
    logic             dir_new;
    logic             deaf_new;

    for (genvar i = 0; i < DAC_W; i++) begin : g_dac
        assign cal_new[i] = tail[CAL_TOP-i];
        assign thr_new[i] = tail[THR_TOP-i];
    end

    assign dir_new  = legacy ? tail[DIR_POS+1]  : tail[DIR_POS];
    assign deaf_new = legacy ? tail[DEAF_POS+1] : tail[DEAF_POS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_mask <= '0;
            cal_mask  <= '0;
            trig_mask <= '0;
            cal_dac   <= '0;
            cal_range <= 1'b0;
            thr_dac   <= '0;
            thr_range <= 1'b0;
            read_dir  <= 1'b0;
            deaf      <= 1'b0;
        end else if (clear) begin
            data_mask <= '0;
            cal_mask  <= '0;
            trig_mask <= '0;
            cal_dac   <= '0;
            cal_range <= 1'b0;
            thr_dac   <= '0;
            thr_range <= 1'b0;
            read_dir  <= 1'b0;
            deaf      <= 1'b0;
        end else begin
            if (ld_dmask) data_mask <= mask_in;
            if (ld_cmask) cal_mask  <= mask_in;
            if (ld_tmask) trig_mask <= mask_in;
            if (ld_dac) begin
                cal_dac   <= cal_new;
                cal_range <= tail[CAL_RNG];
                thr_dac   <= thr_new;
                thr_range <= tail[THR_RNG];
            end
            if (ld_mode) begin
                read_dir <= dir_new;
                deaf     <= deaf_new;
            end
        end
    end
endmodule

// File: rtl/sfe_readback.sv
module sfe_readback
    import sfe_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  rb_sel_e          sel,
    input  logic [PAY_W-1:0] img_dmask,
    input  logic [PAY_W-1:0] img_cmask,
    input  logic [PAY_W-1:0] img_tmask,
    input  logic [DAC_W-1:0] cal_dac,
    input  logic             cal_range,
    input  logic [DAC_W-1:0] thr_dac,
    input  logic             thr_range,
    input  logic             read_dir,
    input  logic             deaf,
    input  logic             legacy,
    output logic             sdo,
    output logic             sdo_vld,
    output logic             last
);
    localparam int CAL_TOP = DAC_FLD_W - 1;
    localparam int CAL_RNG = CAL_TOP - DAC_W;
    localparam int THR_TOP = CAL_RNG - 1;

    logic [PAY_W-1:0] dac_img;
    logic [PAY_W-1:0] mode_img;
    logic [PAY_W-1:0] img;
    logic [PAY_W-1:0] sr_q;
    logic [CNT_W-1:0] left_q;

    always_comb begin
        dac_img = '0;
        for (int i = 0; i < DAC_W; i++) begin
            dac_img[CAL_TOP-i] = cal_dac[i];
            dac_img[THR_TOP-i] = thr_dac[i];
        end
        dac_img[CAL_RNG] = cal_range;
        dac_img[0]       = thr_range;
        mode_img = '0;
        if (legacy) begin
            mode_img[2] = read_dir;
            mode_img[1] = deaf;
        end else begin
            mode_img[1] = read_dir;
            mode_img[0] = deaf;
        end
    end

    always_comb begin
        unique case (sel)
            RB_DMASK: img = img_dmask;
            RB_CMASK: img = img_cmask;
            RB_TMASK: img = img_tmask;
            RB_DAC:   img = dac_img;
            RB_MODE:  img = mode_img;
            default:  img = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sr_q   <= img;
            left_q <= CNT_W'(PAY_W);
        end else if (left_q != '0) begin
            sr_q   <= {sr_q[PAY_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign sdo_vld = (left_q != '0);
    assign sdo     = sdo_vld & sr_q[PAY_W-1];
    assign last    = (left_q == CNT_W'(1));
endmodule

// File: rtl/sfe_cmd_decoder.sv
module sfe_cmd_decoder
    import sfe_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic [ADDR_W-1:0] chip_addr,
    input  logic              legacy_mode,
    input  logic              trig_in,
    output logic              trig_out,
    output logic [CH_N-1:0]   data_mask,
    output logic [CH_N-1:0]   cal_mask,
    output logic [CH_N-1:0]   trig_mask,
    output logic [DAC_W-1:0]  cal_dac,
    output logic              cal_range,
    output logic [DAC_W-1:0]  thr_dac,
    output logic              thr_range,
    output logic              read_dir,
    output logic              deaf,
    output logic              chip_rst,
    output logic              evt_start,
    output logic [EVT_W-1:0]  evt_sel,
    output logic              mask_err,
    output logic              sdo,
    output logic              sdo_vld
);
    state_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [HDR_W-2:0]  hdr_q;
    logic [PAY_W-2:0]  pay_q;
    logic [CODE_W-1:0] code_q;
    logic              match_q;

    logic [HDR_W-1:0]  hdr_now;
    logic [CODE_W-1:0] code_now;
    logic              match_now;
    logic [PAY_W-1:0]  pay_now;

    logic              hdr_done, evt_done, pay_done;
    logic              rb_load, rb_last;
    rb_sel_e           rb_sel;
    logic [CH_N-1:0]   mask_new;
    logic              markers_ok;
    logic              pay_ok;
    logic              ld_dmask, ld_cmask, ld_tmask, ld_dac, ld_mode, do_clear;
    logic [PAY_W-1:0]  img_dmask, img_cmask, img_tmask;

    assign hdr_now   = {hdr_q, sdi};
    assign code_now  = hdr_now[CODE_W-1:0];
    assign match_now = (hdr_now[HDR_W-1 -: ADDR_W] == chip_addr);
    assign pay_now   = {pay_q, sdi};

    // next state and frame-position events
    always_comb begin
        state_d  = state_q;
        hdr_done = 1'b0;
        evt_done = 1'b0;
        pay_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sdi) state_d = ST_HEAD;
            end
            ST_HEAD: begin
                if (cnt_q == CNT_W'(HDR_W-1)) begin
                    hdr_done = 1'b1;
                    if (is_load(code_now))
                        state_d = ST_LOAD;
                    else if (code_now == CMD_EVT)
                        state_d = ST_EVSEL;
                    else if (is_read(code_now) && match_now)
                        state_d = ST_SEND;
                    else
                        state_d = ST_IDLE;
                end
            end
            ST_EVSEL: begin
                if (cnt_q == CNT_W'(EVT_W-1)) begin
                    evt_done = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_LOAD: begin
                if (cnt_q == CNT_W'(PAY_W-1)) begin
                    pay_done = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_SEND: begin
                if (rb_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, bit counter and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hdr_q   <= '0;
            pay_q   <= '0;
            code_q  <= '0;
            match_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (state_q != ST_IDLE && state_q != ST_SEND)
                cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_HEAD)
                hdr_q <= hdr_now[HDR_W-2:0];
            if (state_q == ST_LOAD || state_q == ST_EVSEL)
                pay_q <= pay_now[PAY_W-2:0];
            if (hdr_done) begin
                code_q  <= code_now;
                match_q <= match_now;
            end
        end
    end

    // readback selection
    always_comb begin
        unique case (code_now)
            CMD_RD_CMASK: rb_sel = RB_CMASK;
            CMD_RD_TMASK: rb_sel = RB_TMASK;
            CMD_RD_DAC:   rb_sel = RB_DAC;
            CMD_RD_MODE:  rb_sel = RB_MODE;
            default:      rb_sel = RB_DMASK;
        endcase
    end

    assign rb_load  = hdr_done && match_now && is_read(code_now);
    assign do_clear = hdr_done && match_now && (code_now == CMD_RESET);
    assign pay_ok   = pay_done && match_q;
    assign ld_dmask = pay_ok && markers_ok && (code_q == CMD_LD_DMASK);
    assign ld_cmask = pay_ok && markers_ok && (code_q == CMD_LD_CMASK);
    assign ld_tmask = pay_ok && markers_ok && (code_q == CMD_LD_TMASK);
    assign ld_dac   = pay_ok && (code_q == CMD_LD_DAC);
    assign ld_mode  = pay_ok && (code_q == CMD_LD_MODE);

    // registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_rst  <= 1'b0;
            evt_start <= 1'b0;
            evt_sel   <= '0;
            mask_err  <= 1'b0;
        end else begin
            chip_rst  <= do_clear;
            evt_start <= evt_done && match_q;
            if (evt_done && match_q)
                evt_sel <= pay_now[EVT_W-1:0];
            mask_err  <= pay_ok && is_mask_load(code_q) && !markers_ok;
        end
    end

    assign trig_out = trig_in & ~deaf;

    sfe_mask_unpack u_unpack (
        .payload    (pay_now),
        .mask       (mask_new),
        .markers_ok (markers_ok)
    );

    sfe_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (do_clear),
        .ld_dmask  (ld_dmask),
        .ld_cmask  (ld_cmask),
        .ld_tmask  (ld_tmask),
        .ld_dac    (ld_dac),
        .ld_mode   (ld_mode),
        .legacy    (legacy_mode),
        .mask_in   (mask_new),
        .tail      (pay_now[DAC_FLD_W-1:0]),
        .data_mask (data_mask),
        .cal_mask  (cal_mask),
        .trig_mask (trig_mask),
        .cal_dac   (cal_dac),
        .cal_range (cal_range),
        .thr_dac   (thr_dac),
        .thr_range (thr_range),
        .read_dir  (read_dir),
        .deaf      (deaf)
    );

    sfe_mask_pack u_pack_d (.mask(data_mask), .image(img_dmask));
    sfe_mask_pack u_pack_c (.mask(cal_mask),  .image(img_cmask));
    sfe_mask_pack u_pack_t (.mask(trig_mask), .image(img_tmask));

    sfe_readback u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rb_load),
        .sel       (rb_sel),
        .img_dmask (img_dmask),
        .img_cmask (img_cmask),
        .img_tmask (img_tmask),
        .cal_dac   (cal_dac),
        .cal_range (cal_range),
        .thr_dac   (thr_dac),
        .thr_range (thr_range),
        .read_dir  (read_dir),
        .deaf      (deaf),
        .legacy    (legacy_mode),
        .sdo       (sdo),
        .sdo_vld   (sdo_vld),
        .last      (rb_last)
    );
endmodule

// File: rtl/sfe_cmd_decoder_chk.sv
module sfe_cmd_decoder_chk
    import sfe_cmd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             trig_out,
    input logic [CH_N-1:0]  data_mask,
    input logic [CH_N-1:0]  cal_mask,
    input logic [CH_N-1:0]  trig_mask,
    input logic [DAC_W-1:0] cal_dac,
    input logic             cal_range,
    input logic [DAC_W-1:0] thr_dac,
    input logic             thr_range,
    input logic             read_dir,
    input logic             deaf,
    input logic             chip_rst,
    input logic             evt_start,
    input logic             mask_err,
    input logic             sdo,
    input logic             sdo_vld
);
    assert_strobes_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chip_rst, evt_start, mask_err}));

    assert_err_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_err |=> !mask_err);

    assert_err_keeps_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_err |-> ($stable(data_mask) && $stable(cal_mask) && $stable(trig_mask)));

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |-> (data_mask == '0 && cal_mask == '0 && trig_mask == '0
                      && cal_dac == '0 && !cal_range && thr_dac == '0 && !thr_range
                      && !read_dir && !deaf));

    assert_deaf_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        deaf |-> !trig_out);

    assert_sdo_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_vld |-> !sdo);

    assert_evt_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_start |=> !evt_start);
endmodule

bind sfe_cmd_decoder sfe_cmd_decoder_chk u_chk (.*);

// File: tb/sfe_cmd_decoder_test.sv
module sfe_cmd_decoder_test;
    import sfe_cmd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] MY_ADDR = 5'b10110;
    localparam logic [4:0] OTHER   = 5'b01001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic [4:0]  chip_addr = MY_ADDR;
    logic        legacy_mode = 1'b0;
    logic        trig_in = 1'b0;
    logic        trig_out;
    logic [63:0] data_mask, cal_mask, trig_mask;
    logic [5:0]  cal_dac, thr_dac;
    logic        cal_range, thr_range, read_dir, deaf;
    logic        chip_rst, evt_start, mask_err, sdo, sdo_vld;
    logic [1:0]  evt_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfe_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .chip_addr(chip_addr),
        .legacy_mode(legacy_mode), .trig_in(trig_in), .trig_out(trig_out),
        .data_mask(data_mask), .cal_mask(cal_mask), .trig_mask(trig_mask),
        .cal_dac(cal_dac), .cal_range(cal_range), .thr_dac(thr_dac),
        .thr_range(thr_range), .read_dir(read_dir), .deaf(deaf),
        .chip_rst(chip_rst), .evt_start(evt_start), .evt_sel(evt_sel),
        .mask_err(mask_err), .sdo(sdo), .sdo_vld(sdo_vld)
    );

    // reference model state
    logic [63:0] m_dmask = '0, m_cmask = '0, m_tmask = '0;
    logic [5:0]  m_cal = '0, m_thr = '0;
    logic        m_cr = 1'b0, m_tr = 1'b0, m_dir = 1'b0, m_deaf = 1'b0;
    logic [1:0]  m_sel = '0;
    logic        e_rst = 1'b0, e_evt = 1'b0, e_err = 1'b0, e_vld = 1'b0, e_sdo = 1'b0;
    int          n_run = 0, n_fail = 0, n_tick = 0;
    bit          finished = 1'b0;

    function automatic logic [67:0] mask_img(input logic [63:0] m);
        logic [67:0] v;
        int ch;
        v = '0;
        ch = 63;
        for (int s = 0; s < 68; s++) begin
            if (s % 17 == 0) v[67-s] = 1'b1;
            else begin v[67-s] = m[ch]; ch--; end
        end
        return v;
    endfunction

    function automatic logic [63:0] mask_of(input logic [67:0] v);
        logic [63:0] m;
        int ch;
        m = '0;
        ch = 63;
        for (int s = 0; s < 68; s++) begin
            if (s % 17 != 0) begin m[ch] = v[67-s]; ch--; end
        end
        return m;
    endfunction

    function automatic logic markers_good(input logic [67:0] v);
        return v[67] && v[50] && v[33] && v[16];
    endfunction

    function automatic logic [67:0] dac_img(input logic [5:0] c, input logic cr,
                                            input logic [5:0] t, input logic tr);
        logic [67:0] v;
        v = '0;
        for (int k = 0; k < 14; k++) begin
            if (k < 6)       v[67-(54+k)] = c[k];
            else if (k == 6) v[67-(54+k)] = cr;
            else if (k < 13) v[67-(54+k)] = t[k-7];
            else             v[67-(54+k)] = tr;
        end
        return v;
    endfunction

    function automatic logic [67:0] mode_img(input logic dir, input logic df, input logic leg);
        logic [67:0] v;
        v = '0;
        if (leg) begin v[67-65] = dir; v[67-66] = df; end
        else     begin v[67-66] = dir; v[67-67] = df; end
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input logic [67:0] act, input logic [67:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h (tick %0d)", tag, what, act, exp, n_tick);
        end
    endtask

    task automatic check_all();
        chk("R3", "data_mask", 68'(data_mask), 68'(m_dmask));
        chk("R3", "cal_mask",  68'(cal_mask),  68'(m_cmask));
        chk("R3", "trig_mask", 68'(trig_mask), 68'(m_tmask));
        chk("R5", "dac", 68'({cal_dac, cal_range, thr_dac, thr_range}), 68'({m_cal, m_cr, m_thr, m_tr}));
        chk("R6", "mode", 68'({read_dir, deaf}), 68'({m_dir, m_deaf}));
        chk("R8", "trig_out", 68'(trig_out), 68'(trig_in & ~m_deaf));
        chk("R10", "chip_rst", 68'(chip_rst), 68'(e_rst));
        chk("R9", "evt_start", 68'(evt_start), 68'(e_evt));
        chk("R9", "evt_sel", 68'(evt_sel), 68'(m_sel));
        chk("R4", "mask_err", 68'(mask_err), 68'(e_err));
        chk("R11", "sdo_vld", 68'(sdo_vld), 68'(e_vld));
        chk("R11", "sdo", 68'(sdo), 68'(e_sdo));
    endtask

    // one command clock: drive at the falling edge, compare after the rising edge
    task automatic tick(input logic b);
        sdi = b;
        trig_in = n_tick[1] ^ n_tick[3];
        @(posedge clk);
        @(negedge clk);
        n_tick++;
        check_all();
        e_rst = 1'b0;
        e_evt = 1'b0;
        e_err = 1'b0;
    endtask

    // start bit, address, all code bits but the last (R1)
    task automatic hdr9(input logic [4:0] a, input logic [4:0] c);
        tick(1'b1);
        for (int i = 4; i >= 0; i--) tick(a[i]);
        for (int i = 4; i >= 1; i--) tick(c[i]);
    endtask

    task automatic do_load(input logic [4:0] a, input logic [4:0] c, input logic [67:0] v);
        hdr9(a, c);
        tick(c[0]);
        for (int s = 0; s < 67; s++) tick(v[67-s]);
        if (a == MY_ADDR) begin
            if (c == 5'b01000 || c == 5'b01001 || c == 5'b01010) begin
                if (markers_good(v)) begin
                    if (c == 5'b01000) m_dmask = mask_of(v);
                    if (c == 5'b01001) m_cmask = mask_of(v);
                    if (c == 5'b01010) m_tmask = mask_of(v);
                end else e_err = 1'b1;          // R4
            end else if (c == 5'b01011) begin   // R5
                for (int k = 0; k < 6; k++) begin
                    m_cal[k] = v[67-(54+k)];
                    m_thr[k] = v[67-(61+k)];
                end
                m_cr = v[67-60];
                m_tr = v[0];
            end else if (c == 5'b01100) begin   // R6 / R7
                m_dir  = legacy_mode ? v[67-65] : v[67-66];
                m_deaf = legacy_mode ? v[67-66] : v[67-67];
            end
        end
        tick(v[0]);
    endtask

    task automatic do_short(input logic [4:0] a, input logic [4:0] c);
        hdr9(a, c);
        if (a == MY_ADDR && c == 5'b00010) begin   // R10
            m_dmask = '0; m_cmask = '0; m_tmask = '0;
            m_cal = '0; m_thr = '0; m_cr = 1'b0; m_tr = 1'b0;
            m_dir = 1'b0; m_deaf = 1'b0;
            e_rst = 1'b1;
        end
        tick(c[0]);
    endtask

    task automatic do_evt(input logic [4:0] a, input logic [1:0] b);
        hdr9(a, 5'b00100);
        tick(1'b0);
        tick(b[1]);
        if (a == MY_ADDR) begin e_evt = 1'b1; m_sel = b; end   // R9
        tick(b[0]);
    endtask

    task automatic do_read(input logic [4:0] a, input logic [4:0] c);
        logic [67:0] img;
        unique case (c)
            5'b10000: img = mask_img(m_dmask);
            5'b10001: img = mask_img(m_cmask);
            5'b10010: img = mask_img(m_tmask);
            5'b10011: img = dac_img(m_cal, m_cr, m_thr, m_tr);
            default:  img = mode_img(m_dir, m_deaf, legacy_mode);
        endcase
        hdr9(a, c);
        if (a == MY_ADDR) begin e_vld = 1'b1; e_sdo = img[67]; end   // R11
        tick(c[0]);
        if (a == MY_ADDR) begin
            for (int i = 1; i < 68; i++) begin
                e_sdo = img[67-i];
                tick(1'b0);
            end
            e_vld = 1'b0;
            e_sdo = 1'b0;
            tick(1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all();                                    // reset state, R10
        for (int i = 0; i < 5; i++) tick(1'b0);         // idle zeros, R1

        // R3 mask loads and readback R11
        do_load(MY_ADDR, 5'b01000, mask_img(64'hDEAD_BEEF_0123_8001));
        do_read(MY_ADDR, 5'b10000);
        do_load(MY_ADDR, 5'b01001, mask_img(64'h8000_0000_0000_0001));
        do_load(MY_ADDR, 5'b01010, mask_img(64'h5A5A_F00F_C3C3_7E7E));
        do_read(MY_ADDR, 5'b10001);
        do_read(MY_ADDR, 5'b10010);

        // R4 bad marker in the third group
        do_load(MY_ADDR, 5'b01000, mask_img(64'h1111_2222_3333_4444) & ~(68'd1 << 33));
        do_load(MY_ADDR, 5'b01010, mask_img(64'h0) & ~(68'd1 << 67));

        // R2 foreign address: load, event, read, reset
        do_load(OTHER, 5'b01001, mask_img(64'hFFFF_FFFF_FFFF_FFFF));
        do_evt(OTHER, 2'b11);
        do_read(OTHER, 5'b10000);
        do_short(OTHER, 5'b00010);

        // R5 DAC with junk in the ignored leading bits
        do_load(MY_ADDR, 5'b01011,
                dac_img(6'b100101, 1'b1, 6'b011010, 1'b0) | {54'h2A5A5A5A5A5A5, 14'b0});
        do_read(MY_ADDR, 5'b10011);
        do_load(MY_ADDR, 5'b01011, dac_img(6'b000001, 1'b0, 6'b100000, 1'b1));

        // R6 normal mode layout; R8 gating follows deaf
        do_load(MY_ADDR, 5'b01100, 68'b11);
        for (int i = 0; i < 6; i++) tick(1'b0);
        do_read(MY_ADDR, 5'b10100);
        do_load(MY_ADDR, 5'b01100, 68'b10);

        // R7 legacy layout
        legacy_mode = 1'b1;
        do_load(MY_ADDR, 5'b01100, 68'b101);
        do_read(MY_ADDR, 5'b10100);
        do_load(MY_ADDR, 5'b01100, 68'b010);
        for (int i = 0; i < 6; i++) tick(1'b0);
        legacy_mode = 1'b0;

        // R9 read-event
        do_evt(MY_ADDR, 2'b10);
        do_evt(MY_ADDR, 2'b01);

        // R12 no-op and unassigned code, then a frame right away
        do_short(MY_ADDR, 5'b00000);
        do_short(MY_ADDR, 5'b00001);
        do_load(MY_ADDR, 5'b01001, mask_img(64'h0F0F_0F0F_0F0F_0F0F));
        do_short(MY_ADDR, 5'b11111);
        do_evt(MY_ADDR, 2'b11);

        // R10 chip reset
        do_short(MY_ADDR, 5'b00010);
        do_read(MY_ADDR, 5'b10001);
        for (int i = 0; i < 4; i++) tick(1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule